// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core stops normal execution and hands instruction fetch to the development port. Event pulses from the core, from the development port and from general debug sources set bits in a cause register. An enable mask, a global debug-enable bit and two machine-state bits (machine-check enable and recoverable-interrupt) decide whether a recorded cause takes the core into debug mode. Once an entry qualifies, the block waits for the pipeline to report empty. It then raises a fetch request toward the development port, asserts freeze so that peripherals can halt, and drives a two-bit status code of 2'b11.

A detected machine check has three possible outcomes. It can stop the core in a checkstop state that only reset clears. It can branch to the machine check interrupt, shown as a one-cycle pulse. Or it can enter debug mode. The outcome depends on debug-enable, machine-check-enable and two mask bits. The cause register returns its contents on a read strobe and clears in the same access. An explicit return strobe leaves debug mode.

Cause bit layout: bit 0 marks a machine check taken while machine-check-enable was 0, bit 1 a machine check taken while it was 1, bit 2 a peripheral breakpoint, bit 3 a development-port non-maskable request, and bits 4 and up are general events `evt_i[0]` onward. Mask bit n enables cause bit n. Mask bit 0 acts as the checkstop-enable and mask bit 1 as the machine-check-interrupt-enable.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: An event pulse sampled at a clock edge sets its cause bit, visible on `cause_o` after that edge, and the bit holds until a read.
- R2: While `cause_rd_i` is high, `cause_o` shows the current contents. After that edge the register holds only the bits set in the same cycle.
- R3: Debug mode is entered only if `dbg_en_i` is 1 and some cause bit is set together with its mask bit, or if cause bit 3 (non-maskable request) is set. Otherwise `fetch_req_o` stays 0.
- R4: After an entry qualifies, `fetch_req_o` rises only on the edge after a cycle with `pipe_empty_i` high. With the pipeline already empty it rises two edges after the event edge.
- R5: In debug mode `fetch_req_o` and `freeze_o` are 1 and `stat_o` is 2'b11. Outside debug mode `stat_o` is 2'b00.
- R6: `sw_freeze_i` drives `freeze_o` only while `dbg_en_i` is 0.
- R7: With `dbg_en_i` 0, a machine check goes to checkstop when `me_i` is 0 and gives a `mc_branch_o` pulse after the edge when `me_i` is 1. These outcomes apply only outside debug mode; in debug mode the machine check is only recorded.
- R8: With `dbg_en_i` 1 and `me_i` 0, a machine check sets cause bit 0 and goes to checkstop if mask bit 0 is 0, or enters debug mode if it is 1.
- R9: With `dbg_en_i` 1 and `me_i` 1, a machine check sets cause bit 1 and branches to the interrupt if mask bit 1 is 0, or enters debug mode if it is 1.
- R10: A peripheral breakpoint sets cause bit 2 only when `ri_i` is 1.
- R11: A non-maskable request enters debug mode regardless of mask and debug-enable. If `ri_i` is 0 at that moment, `nonrestart_o` is set; it clears on return from debug mode.
- R12: Debug mode is left only on `dbg_ret_i`, after which `fetch_req_o`, `freeze_o` and `stat_o` return to 0.
- R13: Checkstop (`chkstop_o`) is sticky until reset and blocks every later debug entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en_i | input | 1 | Global debug-mode enable |
| me_i | input | 1 | Machine-check enable state bit |
| ri_i | input | 1 | Recoverable-interrupt state bit |
| mask_i | input | CAUSE_W | Per-cause enable mask |
| evt_i | input | CAUSE_W-4 | General debug event pulses |
| mchk_i | input | 1 | Machine check detected pulse |
| pbrk_i | input | 1 | Peripheral breakpoint pulse from the development port |
| nmi_i | input | 1 | Non-maskable development-port request pulse |
| pipe_empty_i | input | 1 | Pipeline empty flag |
| cause_rd_i | input | 1 | Cause register read strobe (clears it) |
| sw_freeze_i | input | 1 | Software freeze request |
| dbg_ret_i | input | 1 | Return-from-debug strobe |
| cause_o | output | CAUSE_W | Cause register contents |
| fetch_req_o | output | 1 | Fetch from development port request |
| freeze_o | output | 1 | Freeze indication |
| stat_o | output | 2 | Status code (2'b11 in debug mode) |
| chkstop_o | output | 1 | Checkstop state |
| mc_branch_o | output | 1 | Branch to machine check interrupt pulse |
| nonrestart_o | output | 1 | Debug entry made from a non-restartable state |

## Verification
Several results appear one edge after the stimulus edge: the cause bits, checkstop, the branch pulse and the non-restartable flag. The fetch request and status code appear one edge later, because the sequencer reads the registered cause value. Freeze under software control is combinational. The bench drives every input on a falling edge and samples at the falling edges that follow the edges where each result is due: one falling edge for cause and machine-check outcomes, two for debug entry. Combinational freeze is read a short delay after its input changes. The pipeline-wait case holds the empty flag low for an extra edge and checks that the request stays off, then releases it and checks that the request arrives exactly one edge later.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    // Fixed cause bit positions; general events start at CB_GEN0
    localparam int CB_MC_STOP   = 0;
    localparam int CB_MC_INT    = 1;
    localparam int CB_PBRK      = 2;
    localparam int CB_NMI       = 3;
    localparam int CB_GEN0      = 4;
    localparam int FIXED_CAUSES = 4;

    localparam logic [1:0] STAT_RUN   = 2'b00;
    localparam logic [1:0] STAT_DEBUG = 2'b11;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_DEBUG = 2'd2,
        ST_STOP  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        MC_NONE   = 2'd0,
        MC_STOP   = 2'd1,
        MC_BRANCH = 2'd2,
        MC_DEBUG  = 2'd3
    } mc_disp_e;

    typedef struct packed {
        logic dbg_en;
        logic me;
        logic ri;
    } mstate_t;

    // Outcome of a machine check given debug enable, machine-check enable
    // and the two mask bits that govern it.
    function automatic mc_disp_e mc_route(input logic dbg_en, input logic me,
                                          input logic stop_en, input logic int_en);
        if (!dbg_en)
            return me ? MC_BRANCH : MC_STOP;
        if (!me)
            return stop_en ? MC_DEBUG : MC_STOP;
        return int_en ? MC_DEBUG : MC_BRANCH;
    endfunction

endpackage

// File: rtl/dbg_event_map.sv
module dbg_event_map
    import dbg_pkg::*;
#(
    parameter int CAUSE_W = 8,
    localparam int GEN_W  = CAUSE_W - FIXED_CAUSES
) (
    input  mstate_t            mst,
    input  logic               stop_en,
    input  logic               int_en,
    input  logic               active,
    input  logic               mchk,
    input  logic               pbrk,
    input  logic               nmi,
    input  logic [GEN_W-1:0]   gen_evt,
    output logic [CAUSE_W-1:0] set_vec,
    output logic               go_stop,
    output logic               go_branch,
    output logic               nr_set
);

    mc_disp_e disp;

    always_comb begin
        disp = MC_NONE;
        if (mchk)
            disp = mc_route(mst.dbg_en, mst.me, stop_en, int_en);
    end

    assign set_vec[CB_MC_STOP] = mchk & ~mst.me;
    assign set_vec[CB_MC_INT]  = mchk &  mst.me;
    assign set_vec[CB_PBRK]    = pbrk &  mst.ri;
    assign set_vec[CB_NMI]     = nmi;

    for (genvar g = 0; g < GEN_W; g++) begin : g_gen
        assign set_vec[CB_GEN0+g] = gen_evt[g];
    end

    assign go_stop   = active & (disp == MC_STOP);
    assign go_branch = active & (disp == MC_BRANCH);
    assign nr_set    = nmi & ~mst.ri;

endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg #(
    parameter int CAUSE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               rd,
    output logic [CAUSE_W-1:0] cause_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else if (rd)
            cause_q <= set_vec;
        else
            cause_q <= cause_q | set_vec;
    end

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd |=> ((cause_q & $past(cause_q)) == $past(cause_q)));  // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && set_vec == '0) |=> (cause_q == '0));  // R2

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       qual,
    input  logic       pipe_empty,
    input  logic       go_stop,
    input  logic       go_branch,
    input  logic       nr_set,
    input  logic       ret,
    output logic       in_debug,
    output logic       active,
    output logic       chkstop,
    output logic       mc_branch,
    output logic       nonrestart,
    output logic [1:0] stat
);

    seq_state_e state_q, state_d;
    logic       leave;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go_stop)
                    state_d = ST_STOP;
                else if (qual)
                    state_d = pipe_empty ? ST_DEBUG : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (go_stop)
                    state_d = ST_STOP;
                else if (pipe_empty)
                    state_d = ST_DEBUG;
            end
            ST_DEBUG: begin
                if (ret)
                    state_d = ST_RUN;
            end
            ST_STOP: state_d = ST_STOP;
            default: state_d = ST_RUN;
        endcase
    end

    assign leave = (state_q == ST_DEBUG) & ret;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            mc_branch  <= 1'b0;
            nonrestart <= 1'b0;
        end else begin
            state_q    <= state_d;
            mc_branch  <= go_branch;
            nonrestart <= (nonrestart & ~leave) | nr_set;
        end
    end

    assign in_debug = (state_q == ST_DEBUG);
    assign active   = (state_q == ST_RUN) | (state_q == ST_DRAIN);
    assign chkstop  = (state_q == ST_STOP);
    assign stat     = in_debug ? STAT_DEBUG : STAT_RUN;

    AST_FETCH_AFTER_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(in_debug) |-> $past(pipe_empty));  // R4

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !qual) |=> !in_debug);  // R3

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        chkstop |=> chkstop);  // R13

    AST_STAY_UNTIL_RET: assert property (@(posedge clk) disable iff (rst)
        (in_debug && !ret) |=> in_debug);  // R12

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_pkg::*;
#(
    parameter int CAUSE_W = 8,
    localparam int GEN_W  = CAUSE_W - FIXED_CAUSES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dbg_en_i,
    input  logic               me_i,
    input  logic               ri_i,
    input  logic [CAUSE_W-1:0] mask_i,
    input  logic [GEN_W-1:0]   evt_i,
    input  logic               mchk_i,
    input  logic               pbrk_i,
    input  logic               nmi_i,
    input  logic               pipe_empty_i,
    input  logic               cause_rd_i,
    input  logic               sw_freeze_i,
    input  logic               dbg_ret_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               fetch_req_o,
    output logic               freeze_o,
    output logic [1:0]         stat_o,
    output logic               chkstop_o,
    output logic               mc_branch_o,
    output logic               nonrestart_o
);

    mstate_t            mst;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] cause_q;
    logic               go_stop, go_branch, nr_set;
    logic               active, in_debug, qual;

    assign mst = '{dbg_en: dbg_en_i, me: me_i, ri: ri_i};

    dbg_event_map #(.CAUSE_W(CAUSE_W)) u_map (
        .mst       (mst),
        .stop_en   (mask_i[CB_MC_STOP]),
        .int_en    (mask_i[CB_MC_INT]),
        .active    (active),
        .mchk      (mchk_i),
        .pbrk      (pbrk_i),
        .nmi       (nmi_i),
        .gen_evt   (evt_i),
        .set_vec   (set_vec),
        .go_stop   (go_stop),
        .go_branch (go_branch),
        .nr_set    (nr_set)
    );

    dbg_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .rd      (cause_rd_i),
        .cause_q (cause_q)
    );

    assign qual = (dbg_en_i & (|(cause_q & mask_i))) | cause_q[CB_NMI];

    dbg_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .qual       (qual),
        .pipe_empty (pipe_empty_i),
        .go_stop    (go_stop),
        .go_branch  (go_branch),
        .nr_set     (nr_set),
        .ret        (dbg_ret_i),
        .in_debug   (in_debug),
        .active     (active),
        .chkstop    (chkstop_o),
        .mc_branch  (mc_branch_o),
        .nonrestart (nonrestart_o),
        .stat       (stat_o)
    );

    assign cause_o     = cause_q;
    assign fetch_req_o = in_debug;
    assign freeze_o    = in_debug | (sw_freeze_i & ~dbg_en_i);

    AST_SW_FREEZE_GATED: assert property (@(posedge clk) disable iff (rst)
        (dbg_en_i && !fetch_req_o) |-> !freeze_o);  // R6

    AST_DEBUG_STATUS: assert property (@(posedge clk) disable iff (rst)
        fetch_req_o |-> (stat_o == 2'b11 && freeze_o));  // R5

    AST_ME_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        (mchk_i && me_i && !chkstop_o) |=> !chkstop_o);  // R7

    AST_PBRK_NEEDS_RI: assert property (@(posedge clk) disable iff (rst)
        (pbrk_i && !ri_i && !cause_o[CB_PBRK]) |=> !cause_o[CB_PBRK]);  // R10

endmodule

// File: tb/sim_dbg_entry_ctrl.sv
module sim_dbg_entry_ctrl;

    localparam int CW = 8;
    localparam int GW = CW - 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg_en, me, ri, mchk, pbrk, nmi, pipe_empty, cause_rd, sw_freeze, dbg_ret;
    logic [CW-1:0] mask;
    logic [GW-1:0] evt;
    logic [CW-1:0] cause;
    logic fetch_req, freeze, chkstop, mc_branch, nonrestart;
    logic [1:0] stat;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;  // 50 MHz

    dbg_entry_ctrl #(.CAUSE_W(CW)) u0 (
        .clk(clk), .rst(rst), .dbg_en_i(dbg_en), .me_i(me), .ri_i(ri),
        .mask_i(mask), .evt_i(evt), .mchk_i(mchk), .pbrk_i(pbrk), .nmi_i(nmi),
        .pipe_empty_i(pipe_empty), .cause_rd_i(cause_rd), .sw_freeze_i(sw_freeze),
        .dbg_ret_i(dbg_ret), .cause_o(cause), .fetch_req_o(fetch_req),
        .freeze_o(freeze), .stat_o(stat), .chkstop_o(chkstop),
        .mc_branch_o(mc_branch), .nonrestart_o(nonrestart)
    );

    // kind: 0 machine check, 1 peripheral breakpoint, 2 non-maskable, 3 general event 0
    typedef struct packed {
        logic [1:0] kind;
        logic       dbg;
        logic       me;
        logic       ri;
        logic [7:0] mask;
        logic       x_stop;
        logic       x_br;
        logic       x_dbg;
        logic       x_nr;
        logic [7:0] x_cause;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},  // R7 stop
        '{2'd0, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02},  // R7 branch
        '{2'd0, 1'b1, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},  // R8 stop
        '{2'd0, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01},  // R8 debug
        '{2'd0, 1'b1, 1'b1, 1'b1, 8'hFD, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02},  // R9 branch
        '{2'd0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02},  // R9 debug
        '{2'd1, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04},  // R10 accepted
        '{2'd1, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R10 ignored
        '{2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08},  // R11 no ri
        '{2'd2, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h08},  // R11 ri
        '{2'd3, 1'b1, 1'b0, 1'b1, 8'hEF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10},  // R3 masked
        '{2'd3, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10}   // R3 enabled
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        dbg_en = 0; me = 0; ri = 0; mchk = 0; pbrk = 0; nmi = 0;
        pipe_empty = 1; cause_rd = 0; sw_freeze = 0; dbg_ret = 0;
        mask = '0; evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fire(input logic [1:0] kind);
        case (kind)
            2'd0: mchk = 1'b1;
            2'd1: pbrk = 1'b1;
            2'd2: nmi  = 1'b1;
            default: evt[0] = 1'b1;
        endcase
        @(negedge clk);
        mchk = 0; pbrk = 0; nmi = 0; evt = '0;
    endtask

    initial begin
        // Reset state
        do_reset();
        chk("R5", "reset fetch_req", {31'd0, fetch_req}, 32'd0);
        chk("R5", "reset stat", {30'd0, stat}, 32'd0);
        chk("R1", "reset cause", {24'd0, cause}, 32'd0);
        chk("R13", "reset chkstop", {31'd0, chkstop}, 32'd0);
        chk("R11", "reset nonrestart", {31'd0, nonrestart}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            dbg_en = VEC[i].dbg; me = VEC[i].me; ri = VEC[i].ri; mask = VEC[i].mask;
            @(negedge clk);
            fire(VEC[i].kind);
            chk("R1", $sformatf("vec%0d cause", i), {24'd0, cause}, {24'd0, VEC[i].x_cause});
            chk("R7", $sformatf("vec%0d chkstop", i), {31'd0, chkstop}, {31'd0, VEC[i].x_stop});
            chk("R9", $sformatf("vec%0d mc_branch", i), {31'd0, mc_branch}, {31'd0, VEC[i].x_br});
            chk("R11", $sformatf("vec%0d nonrestart", i), {31'd0, nonrestart}, {31'd0, VEC[i].x_nr});
            @(negedge clk);
            chk("R8", $sformatf("vec%0d fetch_req", i), {31'd0, fetch_req}, {31'd0, VEC[i].x_dbg});
            chk("R5", $sformatf("vec%0d stat", i), {30'd0, stat}, VEC[i].x_dbg ? 32'd3 : 32'd0);
            chk("R5", $sformatf("vec%0d freeze", i), {31'd0, freeze}, {31'd0, VEC[i].x_dbg});
            chk("R13", $sformatf("vec%0d chkstop held", i), {31'd0, chkstop}, {31'd0, VEC[i].x_stop});
        end

        // R2: read returns contents then clears
        do_reset();
        fire(2'd3);
        cause_rd = 1'b1;
        #1;
        chk("R2", "cause during read", {24'd0, cause}, 32'h10);
        @(negedge clk);
        cause_rd = 1'b0;
        chk("R2", "cause after read", {24'd0, cause}, 32'd0);

        // R4: wait for empty pipeline
        do_reset();
        dbg_en = 1; mask = 8'hFF; pipe_empty = 0;
        fire(2'd3);
        repeat (2) @(negedge clk);
        chk("R4", "no fetch while busy", {31'd0, fetch_req}, 32'd0);
        pipe_empty = 1'b1;
        @(negedge clk);
        chk("R4", "fetch after empty", {31'd0, fetch_req}, 32'd1);

        // R11 / R12: non-restartable entry, return clears outputs and flag
        do_reset();
        fire(2'd2);
        @(negedge clk);
        chk("R11", "nmi entry", {31'd0, fetch_req}, 32'd1);
        chk("R11", "nonrestart set", {31'd0, nonrestart}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R12", "stay without ret", {31'd0, fetch_req}, 32'd1);
        cause_rd = 1; dbg_ret = 1;
        @(negedge clk);
        cause_rd = 0; dbg_ret = 0;
        chk("R12", "fetch after ret", {31'd0, fetch_req}, 32'd0);
        chk("R12", "freeze after ret", {31'd0, freeze}, 32'd0);
        chk("R12", "stat after ret", {30'd0, stat}, 32'd0);
        chk("R11", "nonrestart after ret", {31'd0, nonrestart}, 32'd0);
        @(negedge clk);
        chk("R3", "no re-entry after read", {31'd0, fetch_req}, 32'd0);

        // R6: software freeze gated by debug enable
        do_reset();
        sw_freeze = 1;
        #1;
        chk("R6", "sw freeze honoured", {31'd0, freeze}, 32'd1);
        dbg_en = 1;
        #1;
        chk("R6", "sw freeze blocked", {31'd0, freeze}, 32'd0);
        sw_freeze = 0;

        // R7: machine check in debug mode is only recorded
        do_reset();
        dbg_en = 1; mask = 8'hFE;
        fire(2'd3);
        @(negedge clk);
        chk("R7", "in debug before mc", {31'd0, fetch_req}, 32'd1);
        fire(2'd0);
        chk("R7", "no stop in debug", {31'd0, chkstop}, 32'd0);
        chk("R7", "mc recorded in debug", {31'd0, cause[0]}, 32'd1);
        chk("R7", "still in debug", {31'd0, fetch_req}, 32'd1);

        // R13: checkstop sticky, blocks entry
        do_reset();
        fire(2'd0);
        dbg_en = 1; mask = 8'hFF;
        fire(2'd2);
        repeat (3) @(negedge clk);
        chk("R13", "stop sticky", {31'd0, chkstop}, 32'd1);
        chk("R13", "no entry from stop", {31'd0, fetch_req}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule